// File: doc/BRIEF.md
# Time-Multiplexed Multi-Channel Timer

A bank of `NCH` timer channels that share one update engine. An external pulse marks each microsecond. When it arrives, a sequencer visits the channels one per clock cycle. The shared logic reads that channel's state, computes the next value and writes it back. Each channel therefore moves forward once per microsecond, and no channel has a counter of its own running in parallel.

Each channel is set up through a small register port. It holds a control word, a reload value, a compare value and a live count. Its count steps at one of four time bases: the base unit, or ten, a hundred or a thousand times it. The base unit is `BASE_US` ticks, which is 0.1 ms by default. A private sub-counter for each channel starts when the channel is loaded, so the step boundaries line up with the moment the channel started. A channel runs in one of three ways:

- As a one-shot timeout.
- As a periodic timeout, which sets a sticky flag on each expiry.
- As a PWM generator, which drives a pin that is high while the count is below the compare value.

The channel count and the count width are parameters. The register format does not change with them.

Top module: `mtimer`

## Requirements
- R1: After reset, all expiry flags and PWM pins are 0, and every register and count reads 0.
- R2: The registers read back combinationally through `rd_ch`/`rd_addr`:
  - address 0 is control, with bit 0 run, bit 1 periodic, bit 2 PWM and bits [4:3] time base;
  - address 1 is reload;
  - address 2 is compare;
  - address 3 is the live count.
- R3: A write to control or reload is applied at the channel's next scan slot, which comes after the next tick. At that slot the count is loaded with reload−1. Before that slot, the count is unchanged.
- R4: A running channel steps its count once every `BASE_US`·10^sel ticks, counted from the load.
- R5: In one-shot mode, the step that finds the count at 0 sets the channel's expiry flag, leaves the count at 0 and stops the channel.
- R6: In periodic mode, the step that finds the count at 0 sets the expiry flag and reloads reload−1. With reload value R, this repeats every R steps.
- R7: Writing 1 to bit 0 of address 3 clears the channel's expiry flag. Writing 0 has no effect. A write for one channel does not touch another channel's flag. If a clear and an expiry fall in the same cycle, the expiry wins.
- R8: In PWM mode, the count runs from reload−1 down to 0 and then wraps. The pin is high while count < compare. A change of compare shows at the next slot. PWM mode never sets the expiry flag.
- R9: A channel loaded with run = 0 holds its count and never expires.
- R10: A reload value of 0 behaves as 1.
- R11: Channel i is updated i+1 cycles after the tick edge, and only one channel per cycle. A tick must not arrive while a sweep is still in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse, once per microsecond |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | CHW | Channel selected for the write |
| wr_addr | input | 2 | Register selected for the write |
| wr_data | input | 32 | Write data |
| rd_ch | input | CHW | Channel selected for the read |
| rd_addr | input | 2 | Register selected for the read |
| rd_data | output | 32 | Read data, zero-extended |
| expired | output | NCH | Sticky expiry flag for each channel |
| pwm | output | NCH | PWM pin for each channel |

## Verification
The bench counts ticks from the write and checks the exact tick on which each flag or PWM edge appears.

- **Time base.** An off-by-one in the sub-counter or in the base selection would shift expiry by a whole time base.
- **Deferred load.** The count is read back before the first tick after a write. A design that loaded at once would show the new value too early.
- **One-shot against periodic.** The count and flag are checked several ticks after a one-shot expiry. A design that kept reloading would show a non-zero count or a second expiry.
- **Reload of zero.** A design that underflowed here would wait about 2^32 steps.
- **Slot timing.** On the last channel, the flag is checked on the exact cycle. A sequencer with a wrong slot order or an extra stage would raise it one cycle late.

// File: rtl/mtimer.sv
module mtimer #(
  parameter int NCH     = 4,
  parameter int CW      = 32,
  parameter int BASE_US = 100,
  localparam int CHW    = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           wr_en,
  input  logic [CHW-1:0] wr_ch,
  input  logic [1:0]     wr_addr,
  input  logic [31:0]    wr_data,
  input  logic [CHW-1:0] rd_ch,
  input  logic [1:0]     rd_addr,
  output logic [31:0]    rd_data,
  output logic [NCH-1:0] expired,
  output logic [NCH-1:0] pwm
);
  localparam int L0 = BASE_US;
  localparam int L1 = L0 * 10;
  localparam int L2 = L1 * 10;
  localparam int L3 = L2 * 10;
  localparam int SW = $clog2(L3);

  logic [4:0]    ctrl_r [NCH];
  logic [CW-1:0] rel_r  [NCH];
  logic [CW-1:0] cmp_r  [NCH];
  logic [CW-1:0] cnt_r  [NCH];
  logic [SW-1:0] sub_r  [NCH];
  logic [NCH-1:0] ld_r, act_r, sts_r, pwm_r;

  logic           busy;
  logic [CHW-1:0] idx;

  logic [4:0]    c;
  logic [SW-1:0] lim_m1, n_sub;
  logic [CW-1:0] rel_m1, n_cnt;
  logic          n_act, n_pwm, hit, step;

  assign c      = ctrl_r[idx];
  assign rel_m1 = (rel_r[idx] == '0) ? '0 : rel_r[idx] - 1'b1;
  assign step   = act_r[idx] && (sub_r[idx] == lim_m1);

  always_comb
    case (c[4:3])
      2'd0:    lim_m1 = SW'(L0 - 1);
      2'd1:    lim_m1 = SW'(L1 - 1);
      2'd2:    lim_m1 = SW'(L2 - 1);
      default: lim_m1 = SW'(L3 - 1);
    endcase

  always_comb begin
    n_cnt = cnt_r[idx];
    n_sub = sub_r[idx];
    n_act = act_r[idx];
    hit   = 1'b0;
    if (ld_r[idx]) begin
      n_cnt = rel_m1;
      n_sub = '0;
      n_act = c[0];
    end else if (act_r[idx]) begin
      if (!step) n_sub = sub_r[idx] + 1'b1;
      else begin
        n_sub = '0;
        if (cnt_r[idx] == '0) begin
          hit   = !c[2];
          n_cnt = (c[2] || c[1]) ? rel_m1 : '0;
          n_act = c[2] || c[1];
        end else n_cnt = cnt_r[idx] - 1'b1;
      end
    end
    n_pwm = n_act && c[2] && (n_cnt < cmp_r[idx]);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (tick) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy) begin
      busy <= (idx != CHW'(NCH - 1));
      idx  <= idx + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        ctrl_r[i] <= '0;
        rel_r[i]  <= '0;
        cmp_r[i]  <= '0;
        cnt_r[i]  <= '0;
        sub_r[i]  <= '0;
      end
      ld_r  <= '0;
      act_r <= '0;
      sts_r <= '0;
      pwm_r <= '0;
    end else begin
      if (busy) begin
        cnt_r[idx] <= n_cnt;
        sub_r[idx] <= n_sub;
        act_r[idx] <= n_act;
        pwm_r[idx] <= n_pwm;
        ld_r[idx]  <= 1'b0;
      end
      if (wr_en)
        case (wr_addr)
          2'd0: begin ctrl_r[wr_ch] <= wr_data[4:0];    ld_r[wr_ch] <= 1'b1; end
          2'd1: begin rel_r[wr_ch]  <= wr_data[CW-1:0]; ld_r[wr_ch] <= 1'b1; end
          2'd2: cmp_r[wr_ch] <= wr_data[CW-1:0];
          default: if (wr_data[0]) sts_r[wr_ch] <= 1'b0;
        endcase
      if (busy && hit) sts_r[idx] <= 1'b1;
    end

  always_comb
    case (rd_addr)
      2'd0:    rd_data = 32'(ctrl_r[rd_ch]);
      2'd1:    rd_data = 32'(rel_r[rd_ch]);
      2'd2:    rd_data = 32'(cmp_r[rd_ch]);
      default: rd_data = 32'(cnt_r[rd_ch]);
    endcase

  assign expired = sts_r;
  assign pwm     = pwm_r;
endmodule

// File: rtl/mtimer_chk.sv
module mtimer_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tick,
  input logic           busy,
  input logic           wr_en,
  input logic [1:0]     wr_addr,
  input logic [31:0]    wr_data,
  input logic [NCH-1:0] expired,
  input logic [NCH-1:0] pwm
);
  AST_SWEEP_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> !busy) else $error("sweep overrun"); // R11

  AST_ONE_PIN_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pwm ^ $past(pwm))) else $error("two pins moved"); // R11

  AST_FLAG_SET_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (|(expired & ~$past(expired))) |-> $past(busy)) else $error("flag outside slot"); // R5

  AST_FLAG_CLEAR_BY_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(expired) & ~expired)) |-> $past(wr_en && wr_addr == 2'd3 && wr_data[0]))
    else $error("flag dropped"); // R7

  AST_PWM_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm != $past(pwm)) |-> $past(busy)) else $error("pwm outside slot"); // R8
endmodule

bind mtimer mtimer_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/tb_mtimer.sv
`timescale 1ns/1ps
module tb_mtimer;
  localparam int NCH = 4;
  localparam int CHW = 2;

  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0;
  logic [CHW-1:0] wr_ch = 0, rd_ch = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic [NCH-1:0] expired, pwm;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  mtimer #(.NCH(NCH), .CW(32), .BASE_US(2)) dut (
    .clk, .rst_n, .tick, .wr_en, .wr_ch, .wr_addr, .wr_data,
    .rd_ch, .rd_addr, .rd_data, .expired, .pwm);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_ch = CHW'(ch); wr_addr = 2'(a); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input int ch, input int a, output logic [31:0] d);
    rd_ch = CHW'(ch); rd_addr = 2'(a);
    #1 d = rd_data;
  endtask

  task automatic tick_once();
    @(negedge clk) tick = 1;
    @(negedge clk) tick = 0;
    repeat (6) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick_once();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 expired", 32'(expired), 0);
    chk("R1 pwm", 32'(pwm), 0);
    rd(2, 3, d); chk("R1 count", d, 0);
    rd(2, 1, d); chk("R1 reload", d, 0);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    wr(1, 1, 32'h12345678);
    wr(1, 2, 32'h0000CAFE);
    wr(1, 0, 32'h1A);
    rd(1, 0, d); chk("R2 ctrl", d, 32'h1A);
    rd(1, 1, d); chk("R2 reload", d, 32'h12345678);
    rd(1, 2, d); chk("R2 compare", d, 32'hCAFE);
    rd(1, 3, d); chk("R3 count before slot", d, 0);
    tick_once();
    rd(1, 3, d); chk("R3 count after slot", d, 32'h12345677);
    wr(1, 1, 0); wr(1, 0, 0); tick_once();
  endtask

  task automatic t_oneshot();
    logic [31:0] d;
    wr(0, 1, 3); wr(0, 0, 32'h01);
    ticks(6);
    chk("R4 not yet expired", 32'(expired[0]), 0);
    tick_once();
    chk("R5 expired at step 3", 32'(expired[0]), 1);
    ticks(3);
    rd(0, 3, d); chk("R5 count held at 0", d, 0);
    wr(0, 3, 0);
    chk("R7 write 0 keeps flag", 32'(expired[0]), 1);
    wr(1, 3, 1);
    chk("R7 other channel untouched", 32'(expired[0]), 1);
    wr(0, 3, 1);
    chk("R7 write 1 clears", 32'(expired[0]), 0);
    ticks(4);
    chk("R5 stopped, no re-expiry", 32'(expired[0]), 0);
    wr(0, 0, 0); tick_once();
  endtask

  task automatic t_periodic();
    logic [31:0] d;
    wr(1, 1, 2); wr(1, 0, 32'h03);
    ticks(4);
    chk("R6 before first expiry", 32'(expired[1]), 0);
    tick_once();
    chk("R6 first expiry", 32'(expired[1]), 1);
    rd(1, 3, d); chk("R6 reloaded", d, 1);
    wr(1, 3, 1);
    ticks(3);
    chk("R6 before second expiry", 32'(expired[1]), 0);
    tick_once();
    chk("R6 second expiry", 32'(expired[1]), 1);
    wr(1, 0, 0); wr(1, 3, 1); tick_once();
  endtask

  task automatic t_pwm();
    wr(2, 1, 4); wr(2, 2, 1); wr(2, 0, 32'h05);
    ticks(6);
    chk("R8 pwm low at count 1", 32'(pwm[2]), 0);
    tick_once();
    chk("R8 pwm high at count 0", 32'(pwm[2]), 1);
    tick_once();
    chk("R8 pwm held high", 32'(pwm[2]), 1);
    tick_once();
    chk("R8 pwm low after wrap", 32'(pwm[2]), 0);
    chk("R8 no expiry flag", 32'(expired[2]), 0);
    wr(2, 2, 3);
    tick_once();
    chk("R8 count 3 not below 3", 32'(pwm[2]), 0);
    tick_once();
    chk("R8 new compare applied", 32'(pwm[2]), 1);
    wr(2, 0, 0); tick_once();
    chk("R8 pwm off when stopped", 32'(pwm[2]), 0);
  endtask

  task automatic t_stop();
    logic [31:0] d;
    wr(3, 1, 2); wr(3, 0, 0);
    tick_once();
    ticks(10);
    rd(3, 3, d); chk("R9 count held", d, 1);
    chk("R9 no expiry", 32'(expired[3]), 0);
  endtask

  task automatic t_zero();
    wr(3, 1, 0); wr(3, 0, 32'h01);
    ticks(2);
    chk("R10 not yet", 32'(expired[3]), 0);
    tick_once();
    chk("R10 zero acts as one", 32'(expired[3]), 1);
    wr(3, 3, 1); wr(3, 0, 0); tick_once();
  endtask

  task automatic t_base();
    wr(3, 1, 1); wr(3, 0, 32'h09);
    ticks(20);
    chk("R4 base1 not yet", 32'(expired[3]), 0);
    @(negedge clk) tick = 1;
    @(negedge clk) tick = 0;
    repeat (3) @(negedge clk);
    chk("R11 slot 3 not yet", 32'(expired[3]), 0);
    @(negedge clk);
    chk("R11 slot 3 on time", 32'(expired[3]), 1);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_oneshot();
    t_periodic();
    t_pwm();
    t_stop();
    t_zero();
    t_base();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule